// File: doc/BRIEF.md
# DMA Address Translation Walker

The walker converts a device DMA address into a system address. Each request carries a 64-bit I/O address, a partition number and a read/write flag. A translation-validation entry is fetched from a local table. The table slot is chosen by the partition number and one address bit. The entry either allows a 4 KB identity window, called the bypass path, or describes a radix tree of 8-byte translation entries in system memory. The walker then reads the tree one level at a time through a request/response memory port. Each word that comes back is byte-swapped from big-endian order.

The final entry is checked against the access direction. The walker returns the translated page base, a page mask and the two permission bits, or it raises a fault. It handles one translation at a time, and the busy flag tells the requester when a new request will be taken. The validation table is loaded through a simple write port.

Top module: `dma_xlate_walker`

## Requirements
- R1: A request is taken only while `busy` is low. `busy` rises in the cycle after acceptance and stays high until the cycle in which `done` pulses for exactly one cycle. Requests presented while `busy` is high are ignored.
- R2: An address with any of bits 63:60 set faults without any memory read. On every fault the page, mask and permission outputs are zero.
- R3: The validation entry is read from slot `pe*2 + addr[59]`. Its layout is: [63:28] table address, [27:24] level count, [22:18] table size, [17:13] page size, [12] bypass enable.
- R4: A level count above 4 faults without any memory read.
- R5: A page size of 0 selects bypass, which requires the bypass enable bit. When that bit is set the result is page = addr AND 0x0003_FFFF_FFFF_F000, mask 0xFFF and permission 2'b11. When it is clear the request faults. No memory read is made in either case.
- R6: In translated mode (page size not 0), a table size of 0 faults without any memory read.
- R7: A walk makes level count + 1 reads. With index width w = table size + 8 and page shift p = page size + 11, the first read uses shift w*levels + p and base = table address << 12. Each read goes to base OR (((addr >> shift) AND (2^w - 1)) << 3). The shift then drops by w, and the next base is the returned entry with bits 11:0 cleared.
- R8: Memory data is a big-endian 64-bit word and is byte-reversed before any field of it is used.
- R9: An intermediate entry whose bits 1:0 are both zero ends the walk with a fault, and no further read is made.
- R10: On the final entry a write needs bit 1 and a read needs bit 0, or the walk faults. On success, page = entry AND NOT(2^p - 1), mask = 2^p - 1 and permission = entry bits 1:0.
- R11: A response with the error flag set ends the walk with a fault.
- R12: Once `mem_req_valid` is raised, it and `mem_req_addr` hold steady until `mem_req_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tve_we | input | 1 | Validation table write enable |
| tve_waddr | input | IDX_W | Validation table slot to write |
| tve_wdata | input | 64 | Validation entry to write |
| req_valid | input | 1 | Translation request strobe |
| req_pe | input | PE_W | Partition number |
| req_addr | input | 64 | Device DMA address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| busy | output | 1 | A translation is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion is a fault |
| res_page | output | 64 | Translated page base |
| res_mask | output | 64 | Page offset mask |
| res_perm | output | 2 | Granted permissions (bit 1 write, bit 0 read) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, big-endian |
| mem_rsp_err | input | 1 | Read error |

## Verification
A wrong level counter or shift register shows up in the read addresses and in the number of reads on the memory port. This is visible at the first or second read of a walk, well before `done` arrives. A wrong byte order, base or mask register corrupts `res_page` or `res_mask`, or it trips a valid-bit fault on the very next response. A stuck state shows as `busy` never dropping or as `done` lasting more than one cycle. The busy and handshake rules are watched on every cycle.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int XW_AW = 64;
  localparam logic [63:0] XW_BYP_MASK = 64'h0003_FFFF_FFFF_F000;

  typedef enum logic [1:0] {
    XW_IDLE,
    XW_LOOK,
    XW_ISSUE,
    XW_WAIT
  } xw_state_e;

  typedef struct packed {
    logic        early_done;
    logic        early_fault;
    logic [63:0] byp_page;
    logic [63:0] base;
    logic [7:0]  shift;
    logic [5:0]  iw;
    logic [5:0]  ps;
    logic [2:0]  lv;
  } xw_dec_t;

  function automatic logic [63:0] xw_bswap(input logic [63:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = w[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] xw_slot_addr(input logic [63:0] base,
                                               input logic [63:0] a,
                                               input logic [7:0]  sh,
                                               input logic [5:0]  iw);
    logic [63:0] idx;
    idx = (a >> sh) & ((64'd1 << iw) - 64'd1);
    return base | (idx << 3);
  endfunction

endpackage

// File: rtl/xw_tve_ram.sv
module xw_tve_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [63:0]   wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [63:0]   rdata
);
  logic [63:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/xw_tve_decode.sv
module xw_tve_decode import xw_pkg::*; #(
  parameter int MAX_LV = 4
) (
  input  logic [63:0] tve,
  input  logic [63:0] addr,
  output xw_dec_t     dec
);
  logic [35:0] tbl;
  logic [3:0]  lvf;
  logic [4:0]  tsz;
  logic [4:0]  psz;
  logic        byp_en;
  logic [5:0]  iw;
  logic [5:0]  pgs;
  logic        top_bad;
  logic        lv_bad;
  logic        unused_tve;

  assign unused_tve = ^{tve[23], tve[11:0]};

  always_comb begin
    tbl     = tve[63:28];
    lvf     = tve[27:24];
    tsz     = tve[22:18];
    psz     = tve[17:13];
    byp_en  = tve[12];
    iw      = {1'b0, tsz} + 6'd8;
    pgs     = {1'b0, psz} + 6'd11;
    top_bad = addr[63:60] != 4'd0;
    lv_bad  = lvf > 4'(MAX_LV);

    dec.early_fault = top_bad | lv_bad | ((psz == 5'd0) ? !byp_en : (tsz == 5'd0));
    dec.early_done  = dec.early_fault | (psz == 5'd0);
    dec.byp_page    = addr & XW_BYP_MASK;
    dec.base        = {16'd0, tbl, 12'd0};
    dec.shift       = 8'(iw) * 8'(lvf[2:0]) + 8'(pgs);
    dec.iw          = iw;
    dec.ps          = pgs;
    dec.lv          = lvf[2:0];
  end
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl import xw_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [63:0] req_addr,
  input  logic        req_write,
  output logic        busy,
  output logic [63:0] lat_addr,
  input  xw_dec_t     dec,
  output logic        done,
  output logic        fault,
  output logic [63:0] res_page,
  output logic [63:0] res_mask,
  output logic [1:0]  res_perm,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  input  logic        mem_rsp_err
);
  xw_state_e   state;
  logic [63:0] addr_q;
  logic        wr_q;
  logic [7:0]  shift_q;
  logic [5:0]  iw_q;
  logic [5:0]  ps_q;
  logic [2:0]  lev_q;
  logic [63:0] ent;
  logic [7:0]  nshift;
  logic [63:0] pmask;
  logic        perm_ok;

  assign ent      = xw_bswap(mem_rsp_data);
  assign nshift   = shift_q - {2'b00, iw_q};
  assign pmask    = (64'd1 << ps_q) - 64'd1;
  assign perm_ok  = wr_q ? ent[1] : ent[0];
  assign lat_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= XW_IDLE;
      busy          <= 1'b0;
      done          <= 1'b0;
      fault         <= 1'b0;
      res_page      <= '0;
      res_mask      <= '0;
      res_perm      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      addr_q        <= '0;
      wr_q          <= 1'b0;
      shift_q       <= '0;
      iw_q          <= '0;
      ps_q          <= '0;
      lev_q         <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        XW_IDLE: begin
          if (req_valid) begin
            addr_q <= req_addr;
            wr_q   <= req_write;
            busy   <= 1'b1;
            state  <= XW_LOOK;
          end
        end
        XW_LOOK: begin
          if (dec.early_done) begin
            done     <= 1'b1;
            busy     <= 1'b0;
            state    <= XW_IDLE;
            fault    <= dec.early_fault;
            res_page <= dec.early_fault ? 64'd0 : dec.byp_page;
            res_mask <= dec.early_fault ? 64'd0 : 64'hFFF;
            res_perm <= dec.early_fault ? 2'b00 : 2'b11;
          end else begin
            iw_q          <= dec.iw;
            ps_q          <= dec.ps;
            lev_q         <= dec.lv;
            shift_q       <= dec.shift;
            mem_req_addr  <= xw_slot_addr(dec.base, addr_q, dec.shift, dec.iw);
            mem_req_valid <= 1'b1;
            state         <= XW_ISSUE;
          end
        end
        XW_ISSUE: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= XW_WAIT;
          end
        end
        XW_WAIT: begin
          if (mem_rsp_valid) begin
            if (!mem_rsp_err && lev_q != 3'd0 && ent[1:0] != 2'b00) begin
              lev_q         <= lev_q - 3'd1;
              shift_q       <= nshift;
              mem_req_addr  <= xw_slot_addr({ent[63:12], 12'd0}, addr_q, nshift, iw_q);
              mem_req_valid <= 1'b1;
              state         <= XW_ISSUE;
            end else begin
              done  <= 1'b1;
              busy  <= 1'b0;
              state <= XW_IDLE;
              if (mem_rsp_err || lev_q != 3'd0 || !perm_ok) begin
                fault    <= 1'b1;
                res_page <= '0;
                res_mask <= '0;
                res_perm <= '0;
              end else begin
                fault    <= 1'b0;
                res_page <= ent & ~pmask;
                res_mask <= pmask;
                res_perm <= ent[1:0];
              end
            end
          end
        end
        default: state <= XW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker import xw_pkg::*; #(
  parameter int NUM_PE = 16,
  parameter int MAX_LV = 4,
  localparam int PE_W  = $clog2(NUM_PE),
  localparam int IDX_W = PE_W + 1,
  localparam int DEPTH = 2 * NUM_PE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tve_we,
  input  logic [IDX_W-1:0] tve_waddr,
  input  logic [63:0]      tve_wdata,
  input  logic             req_valid,
  input  logic [PE_W-1:0]  req_pe,
  input  logic [63:0]      req_addr,
  input  logic             req_write,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [63:0]      res_page,
  output logic [63:0]      res_mask,
  output logic [1:0]       res_perm,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [63:0]      mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  input  logic             mem_rsp_err
);
  logic [63:0] tve_q;
  logic [63:0] lat_addr;
  xw_dec_t     dec;
  logic        take;

  assign take = req_valid & ~busy;

  xw_tve_ram #(.DEPTH(DEPTH), .AW(IDX_W)) u_ram (
    .clk   (clk),
    .we    (tve_we),
    .waddr (tve_waddr),
    .wdata (tve_wdata),
    .re    (take),
    .raddr ({req_pe, req_addr[59]}),
    .rdata (tve_q)
  );

  xw_tve_decode #(.MAX_LV(MAX_LV)) u_dec (
    .tve  (tve_q),
    .addr (lat_addr),
    .dec  (dec)
  );

  xw_walk_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (take),
    .req_addr      (req_addr),
    .req_write     (req_write),
    .busy          (busy),
    .lat_addr      (lat_addr),
    .dec           (dec),
    .done          (done),
    .fault         (fault),
    .res_page      (res_page),
    .res_mask      (res_mask),
    .res_perm      (res_perm),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_rsp_err   (mem_rsp_err)
  );
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [63:0] res_mask,
  input logic [1:0]  res_perm,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_drop_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid);

  assert_fault_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (res_perm == 2'b00 && res_mask == 64'd0));

  assert_slot_align_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

  assert_grant_perm_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (res_perm != 2'b00 && (res_mask & 64'hFFF) == 64'hFFF));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind dma_xlate_walker xw_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .busy          (busy),
  .done          (done),
  .fault         (fault),
  .res_mask      (res_mask),
  .res_perm      (res_perm),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/dma_xlate_walker_test.sv
module dma_xlate_walker_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tve_we = 1'b0;
  logic [4:0]  tve_waddr = '0;
  logic [63:0] tve_wdata = '0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_pe = '0;
  logic [63:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        busy, done, fault;
  logic [63:0] res_page, res_mask;
  logic [1:0]  res_perm;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [63:0] rd_log [8];
  logic [63:0] mem_img [logic [63:0]];
  logic [63:0] err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
  logic        got_fault;
  logic [63:0] got_page, got_mask;
  logic [1:0]  got_perm;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xlate_walker uut (.*);

  function automatic logic [63:0] swap8(input logic [63:0] w);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = w[8*(7-i) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] mk_tve(input logic [35:0] tbl, input logic [3:0] lv,
                                         input logic [4:0] ts, input logic [4:0] ps,
                                         input logic be);
    return {tbl, lv, 1'b0, ts, ps, be, 12'h000};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: request seen at negedge, answered one cycle later
  initial begin
    logic pend = 1'b0;
    logic [63:0] pa = '0;
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_img.exists(pa) ? mem_img[pa] : 64'd0;
        mem_rsp_err   = (pa == err_addr);
        pend = 1'b0;
      end
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid && mem_req_ready && !mem_rsp_valid) begin
        pend = 1'b1;
        pa   = mem_req_addr;
        if (rd_cnt < 8) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  task automatic put_tve(input int slot, input logic [63:0] v);
    @(negedge clk);
    tve_we = 1'b1; tve_waddr = 5'(slot); tve_wdata = v;
    @(negedge clk);
    tve_we = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    total++;
    if (!done) begin
      bad++;
      $display("FAIL R1 actual=no_done expected=done");
    end
    got_fault = fault; got_page = res_page; got_mask = res_mask; got_perm = res_perm;
  endtask

  task automatic xlate(input logic [3:0] pe, input logic [63:0] a, input logic wr);
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_pe = pe; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
  endtask

  task automatic expect_fault(input string req, input int reads);
    check(req, 64'(got_fault), 64'd1);
    check(req, got_page, 64'd0);
    check(req, 64'(got_perm), 64'd0);
    check(req, 64'(rd_cnt), 64'(reads));
  endtask

  task automatic t_reset();
    check("R1 reset busy", 64'(busy), 64'd0);
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_bypass();
    xlate(4'd1, 64'h000F_1234_5678_9ABC, 1'b1);
    check("R5 bypass fault", 64'(got_fault), 64'd0);
    check("R5 bypass page", got_page, 64'h0003_1234_5678_9000);
    check("R5 bypass mask", got_mask, 64'hFFF);
    check("R5 bypass perm", 64'(got_perm), 64'd3);
    check("R5 bypass reads", 64'(rd_cnt), 64'd0);
    // same partition, address bit 59 set: slot 3 has bypass disabled
    xlate(4'd1, 64'h080F_1234_5678_9ABC, 1'b0);
    expect_fault("R3 R5 bypass disabled", 0);
  endtask

  task automatic t_top_bits();
    xlate(4'd1, 64'h1000_0000_0000_0000, 1'b0);
    expect_fault("R2 top bits", 0);
  endtask

  task automatic t_bad_fields();
    xlate(4'd2, 64'h0000_0000_0000_1000, 1'b0);
    expect_fault("R4 level count 5", 0);
    xlate(4'd2, 64'h0800_0000_0000_1000, 1'b0);
    expect_fault("R6 table size 0", 0);
  endtask

  task automatic t_one_level();
    xlate(4'd0, 64'h0000_0000_0012_3456, 1'b0);
    check("R7 one-level reads", 64'(rd_cnt), 64'd1);
    check("R7 one-level addr", rd_log[0], 64'h0010_0918);
    check("R8 R10 one-level fault", 64'(got_fault), 64'd0);
    check("R8 R10 one-level page", got_page, 64'hABCD_E000);
    check("R10 one-level mask", got_mask, 64'hFFF);
    check("R10 one-level perm", 64'(got_perm), 64'd3);
  endtask

  task automatic t_two_level();
    xlate(4'd0, 64'h0800_0000_0246_8ACE, 1'b1);
    check("R7 two-level reads", 64'(rd_cnt), 64'd2);
    check("R7 two-level addr0", rd_log[0], 64'h0020_0090);
    check("R7 two-level addr1", rd_log[1], 64'h0030_0340);
    check("R10 write ok fault", 64'(got_fault), 64'd0);
    check("R10 write ok page", got_page, 64'h7777_7000);
    check("R10 write ok perm", 64'(got_perm), 64'd2);
    xlate(4'd0, 64'h0800_0000_0246_8ACE, 1'b0);
    expect_fault("R10 read on write-only", 2);
  endtask

  task automatic t_big_page();
    xlate(4'd3, 64'h0800_0000_4060_0000, 1'b0);
    check("R7 big page addr", rd_log[0], 64'h0040_0018);
    check("R10 big page fault", 64'(got_fault), 64'd0);
    check("R10 big page page", got_page, 64'h8AA0_0000);
    check("R10 big page mask", got_mask, 64'h1F_FFFF);
  endtask

  task automatic t_indirect_bad();
    xlate(4'd3, 64'h0000_0000_0246_8ACE, 1'b0);
    expect_fault("R9 invalid indirect", 1);
  endtask

  task automatic t_mem_err();
    err_addr = 64'h0060_0918;
    xlate(4'd4, 64'h0000_0000_0012_3456, 1'b0);
    expect_fault("R11 memory error", 1);
    err_addr = 64'hFFFF_FFFF_FFFF_FFF8;
  endtask

  task automatic t_busy_ignore();
    int extra = 0;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_pe = 4'd0; req_addr = 64'h0800_0000_0246_8ACE; req_write = 1'b1;
    @(negedge clk);
    check("R1 busy after accept", 64'(busy), 64'd1);
    req_pe = 4'd1; req_addr = 64'h0000_0000_0000_5000; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check("R1 ignored request page", got_page, 64'h7777_7000);
    check("R1 ignored request reads", 64'(rd_cnt), 64'd2);
    repeat (6) begin @(negedge clk); if (done) extra++; end
    check("R1 no second completion", 64'(extra), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mem_img[64'h0010_0918] = swap8(64'h0000_0000_ABCD_E003);
    mem_img[64'h0020_0090] = swap8(64'h0000_0000_0030_0001);
    mem_img[64'h0030_0340] = swap8(64'h0000_0000_7777_7002);
    mem_img[64'h0050_0090] = swap8(64'h0000_0000_0030_0000);
    mem_img[64'h0040_0018] = swap8(64'h0000_0000_8AB0_0003);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    put_tve(0, mk_tve(36'h100, 4'd0, 5'd1, 5'd1, 1'b0));
    put_tve(1, mk_tve(36'h200, 4'd1, 5'd1, 5'd1, 1'b0));
    put_tve(2, mk_tve(36'h0,   4'd0, 5'd0, 5'd0, 1'b1));
    put_tve(3, mk_tve(36'h0,   4'd0, 5'd0, 5'd0, 1'b0));
    put_tve(4, mk_tve(36'h100, 4'd5, 5'd1, 5'd1, 1'b0));
    put_tve(5, mk_tve(36'h100, 4'd0, 5'd0, 5'd1, 1'b0));
    put_tve(6, mk_tve(36'h500, 4'd1, 5'd1, 5'd1, 1'b0));
    put_tve(7, mk_tve(36'h400, 4'd0, 5'd1, 5'd10, 1'b0));
    put_tve(8, mk_tve(36'h600, 4'd0, 5'd1, 5'd1, 1'b0));
    t_bypass();
    t_top_bits();
    t_bad_fields();
    t_one_level();
    t_two_level();
    t_big_page();
    t_indirect_bad();
    t_mem_err();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule